// File: doc/BRIEF.md
# Interleaved-Carrier Three-Level Clamped-Leg Gate Generator

This block drives the six gates of one active neutral-point-clamped inverter leg from a signed modulation reference. The leg has three complementary device pairs: an upper pair (gate_a / gate_a_c), a lower pair (gate_b / gate_b_c) and a clamp pair (gate_c / gate_c_c). The sign of the reference picks the half-wave, and its magnitude sets the duty of the active state. Two triangular carriers come from a single phase counter and sit half a switching period apart. The lead carrier sets the upper pair's decision and the lag carrier sets the lower pair's decision. The two zero-voltage intervals of each period therefore fall at different instants and flow through different device paths. The output shows four active/zero transitions per switching period, which is twice the per-device switching rate.

The reference magnitude and sign are captured only at the carrier valley, so a polarity change never cuts a pulse short. Each complementary pair then passes through its own dead-time stage. A device turns off on the next clock. It turns on only after its partner has been off for a set number of clocks. When the enable input is low, all six gates are forced off and the carrier restarts from its valley.

Top module: `anpc_gate_gen`

## Requirements
- R1: While the synchronous active-high `rst` is asserted, all six gate outputs are low.
- R2: When `en` is sampled low, all six gates are low on the next clock. The phase counter is held at 0 and the reference is captured on every clock, so re-enabling starts a new period at phase 0 with the current reference.
- R3: The phase counts 0 to 2·HALF−1 and wraps. The lead carrier equals the phase while the phase is at most HALF, and 2·HALF minus the phase above that. The lag carrier is HALF minus the lead carrier, which is the same triangle shifted by half a period.
- R4: The magnitude m is |ref_in| saturated at HALF, and the half-wave is negative when ref_in < 0. Both are captured only on the clock where the phase is 2·HALF−1 while enabled. At m = HALF the active-state devices stay on for the whole period.
- R5: The lead comparator is true when 2·lead + m ≥ HALF. In the positive half-wave, gate_a demand equals the lead comparator, gate_a_c demand is its complement, gate_c demand follows gate_a demand, and gate_c_c is held off.
- R6: The lag comparator is true when 2·lag + m > HALF, or when m = HALF. In the positive half-wave, gate_b demand equals the lag comparator and gate_b_c demand is its complement. In both half-waves, the gate_b and gate_b_c demands are complementary.
- R7: In the negative half-wave, gate_b_c demand equals the lead comparator and gate_b demand is its complement. gate_a_c demand equals the lag comparator and gate_a demand is its complement. gate_c_c demand follows gate_b_c demand, and gate_c is held off.
- R8: For 0 < m < HALF, gate_a and gate_b each rise once per period. This gives the sequence zero (lower active only), active, zero (upper active only), active. With m = 0, gate_a and gate_b are never on together.
- R9: Each pair registers its demand, so a device turns off one clock after its demand falls. A device turns on only after its partner has been off for DEAD clocks, and exactly DEAD clocks when its demand was already waiting. The two devices of a pair are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulator enable; low forces all gates off |
| ref_in | input | REF_W | Signed modulation reference (two's complement) |
| gate_a | output | 1 | Upper pair, outer device |
| gate_a_c | output | 1 | Upper pair, complementary device |
| gate_b | output | 1 | Lower pair, device active in the positive half-wave |
| gate_b_c | output | 1 | Lower pair, complementary device |
| gate_c | output | 1 | Clamp pair, device used in the positive half-wave |
| gate_c_c | output | 1 | Clamp pair, device used in the negative half-wave |

## Verification
The assertions check, on every clock, the following properties:
- No pair ever has both devices on.
- Every turn-on is preceded by the partner being off for the dead time.
- All gates fall after the enable drops.
- The captured polarity moves only at a carrier valley or while disabled.
- The lead carrier steps by one.
- The clamp device of the inactive half-wave stays off once the polarity is settled.

Only the bench scenarios can show the following:
- The exact gate pattern against the triangle comparisons.
- The four-transition sequence and the single rise of each modulating device per period.
- Full-scale saturation.
- The zero-reference case without an active state.
- That a mid-period sign change is deferred to the next valley.

// File: rtl/anpc_pkg.sv
package anpc_pkg;

  // Demand or gate levels of the three complementary pairs of the leg.
  typedef struct packed {
    logic a;
    logic a_c;
    logic b;
    logic b_c;
    logic c;
    logic c_c;
  } gate_set_t;

  // Symmetric triangle: rises 0..half over the first half period, falls back after.
  function automatic int unsigned carrier_at(int unsigned phase, int unsigned half);
    return (phase <= half) ? phase : (2 * half - phase);
  endfunction

  // Absolute value of the reference, clipped to the carrier peak.
  function automatic int unsigned ref_mag(int signed val, int unsigned half);
    int unsigned m;
    m = (val < 0) ? unsigned'(-val) : unsigned'(val);
    return (m > half) ? half : m;
  endfunction

  // Lead comparator: inclusive threshold on the doubled carrier.
  function automatic logic lead_on(int unsigned car, int unsigned mag, int unsigned half);
    return (2 * car + mag) >= half;
  endfunction

  // Lag comparator: strict threshold breaks the tie at zero magnitude;
  // full magnitude holds it on across the carrier peak.
  function automatic logic lag_on(int unsigned car, int unsigned mag, int unsigned half);
    return (mag >= half) || ((2 * car + mag) > half);
  endfunction

endpackage

// File: rtl/anpc_carrier.sv
module anpc_carrier #(
  parameter int unsigned HALF  = 50,
  parameter int          PH_W  = $clog2(2 * HALF),
  parameter int          CAR_W = $clog2(HALF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             wrap,
  output logic [CAR_W-1:0] car_lead,
  output logic [CAR_W-1:0] car_lag
);
  import anpc_pkg::*;

  localparam int unsigned PER = 2 * HALF;

  logic [PH_W-1:0] phase_q;

  assign wrap = (phase_q == PH_W'(PER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (!en || wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // One counter feeds both carriers; the lag carrier is the lead one
  // moved by half a period, which for a triangle is its mirror about HALF/2.
  assign car_lead = CAR_W'(carrier_at(32'(phase_q), HALF));
  assign car_lag  = CAR_W'(HALF) - car_lead;

endmodule

// File: rtl/anpc_ref_latch.sv
module anpc_ref_latch #(
  parameter int unsigned HALF  = 50,
  parameter int          REF_W = 12,
  parameter int          CAR_W = $clog2(HALF + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    wrap,
  input  logic signed [REF_W-1:0] ref_in,
  output logic [CAR_W-1:0]        mag_q,
  output logic                    neg_q
);
  import anpc_pkg::*;

  logic load;

  // Capture at the valley only; while idle follow the input every clock.
  assign load = !en || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
      neg_q <= 1'b0;
    end else if (load) begin
      mag_q <= CAR_W'(ref_mag(int'(ref_in), HALF));
      neg_q <= ref_in[REF_W-1];
    end
  end

endmodule

// File: rtl/anpc_leg_map.sv
module anpc_leg_map #(
  parameter int unsigned HALF  = 50,
  parameter int          CAR_W = $clog2(HALF + 1)
) (
  input  logic                 en,
  input  logic [CAR_W-1:0]     mag,
  input  logic                 neg,
  input  logic [CAR_W-1:0]     car_lead,
  input  logic [CAR_W-1:0]     car_lag,
  output anpc_pkg::gate_set_t  dem
);
  import anpc_pkg::*;

  logic on_lead;
  logic on_lag;

  assign on_lead = lead_on(32'(car_lead), 32'(mag), HALF);
  assign on_lag  = lag_on(32'(car_lag), 32'(mag), HALF);

  always_comb begin
    dem = '0;
    if (en) begin
      if (!neg) begin
        dem.a   = on_lead;
        dem.a_c = !on_lead;
        dem.b   = on_lag;
        dem.b_c = !on_lag;
        dem.c   = on_lead;
        dem.c_c = 1'b0;
      end else begin
        dem.b_c = on_lead;
        dem.b   = !on_lead;
        dem.a_c = on_lag;
        dem.a   = !on_lag;
        dem.c_c = on_lead;
        dem.c   = 1'b0;
      end
    end
  end

endmodule

// File: rtl/anpc_dead_pair.sv
module anpc_dead_pair #(
  parameter int unsigned DEAD  = 3,
  parameter int          GAP_W = $clog2(DEAD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic dem_p,
  input  logic dem_n,
  output logic out_p,
  output logic out_n
);
  logic [GAP_W-1:0] gap_q;
  logic             may_rise;

  // gap_q counts clocks with both devices off; the rising edge itself is
  // the last off clock, hence the minus one.
  assign may_rise = (gap_q >= GAP_W'(DEAD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_p <= 1'b0;
      out_n <= 1'b0;
      gap_q <= '0;
    end else begin
      out_p <= dem_p && (out_p || (!out_n && may_rise));
      out_n <= dem_n && (out_n || (!out_p && may_rise));
      if (out_p || out_n) begin
        gap_q <= '0;
      end else if (gap_q != GAP_W'(DEAD)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/anpc_gate_gen.sv
module anpc_gate_gen #(
  parameter int unsigned HALF  = 50,
  parameter int          REF_W = 12,
  parameter int unsigned DEAD  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_in,
  output logic                    gate_a,
  output logic                    gate_a_c,
  output logic                    gate_b,
  output logic                    gate_b_c,
  output logic                    gate_c,
  output logic                    gate_c_c
);
  import anpc_pkg::*;

  localparam int PH_W  = $clog2(2 * HALF);
  localparam int CAR_W = $clog2(HALF + 1);
  localparam int GAP_W = $clog2(DEAD + 1);
  localparam int NPAIR = 3;

  logic             wrap;
  logic [CAR_W-1:0] car_lead;
  logic [CAR_W-1:0] car_lag;
  logic [CAR_W-1:0] mag_q;
  logic             neg_q;
  gate_set_t        dem;
  logic [NPAIR-1:0] dem_p;
  logic [NPAIR-1:0] dem_n;
  logic [NPAIR-1:0] out_p;
  logic [NPAIR-1:0] out_n;

  anpc_carrier #(.HALF(HALF), .PH_W(PH_W), .CAR_W(CAR_W)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .wrap     (wrap),
    .car_lead (car_lead),
    .car_lag  (car_lag)
  );

  anpc_ref_latch #(.HALF(HALF), .REF_W(REF_W), .CAR_W(CAR_W)) u_ref (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .wrap   (wrap),
    .ref_in (ref_in),
    .mag_q  (mag_q),
    .neg_q  (neg_q)
  );

  anpc_leg_map #(.HALF(HALF), .CAR_W(CAR_W)) u_map (
    .en       (en),
    .mag      (mag_q),
    .neg      (neg_q),
    .car_lead (car_lead),
    .car_lag  (car_lag),
    .dem      (dem)
  );

  assign dem_p = {dem.c, dem.b, dem.a};
  assign dem_n = {dem.c_c, dem.b_c, dem.a_c};

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    anpc_dead_pair #(.DEAD(DEAD), .GAP_W(GAP_W)) u_dead (
      .clk   (clk),
      .rst   (rst),
      .dem_p (dem_p[i]),
      .dem_n (dem_n[i]),
      .out_p (out_p[i]),
      .out_n (out_n[i])
    );
  end

  assign gate_a   = out_p[0];
  assign gate_a_c = out_n[0];
  assign gate_b   = out_p[1];
  assign gate_b_c = out_n[1];
  assign gate_c   = out_p[2];
  assign gate_c_c = out_n[2];

endmodule

// File: rtl/anpc_gate_gen_chk.sv
module anpc_gate_gen_chk #(
  parameter int unsigned DEAD  = 3,
  parameter int          CAR_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             wrap,
  input logic             neg_q,
  input logic [CAR_W-1:0] car_lead,
  input logic             gate_a,
  input logic             gate_a_c,
  input logic             gate_b,
  input logic             gate_b_c,
  input logic             gate_c,
  input logic             gate_c_c
);
  localparam int CW = $clog2(DEAD + 1);

  logic [5:0] g;
  assign g = {gate_c_c, gate_c, gate_b_c, gate_b, gate_a_c, gate_a};

  for (genvar k = 0; k < 3; k++) begin : g_pair_chk
    logic [CW-1:0] off_p;
    logic [CW-1:0] off_n;

    always_ff @(posedge clk) begin
      if (rst) begin
        off_p <= '0;
        off_n <= '0;
      end else begin
        off_p <= g[2*k]   ? '0 : ((off_p == CW'(DEAD)) ? off_p : off_p + 1'b1);
        off_n <= g[2*k+1] ? '0 : ((off_n == CW'(DEAD)) ? off_n : off_n + 1'b1);
      end
    end

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(g[2*k] && g[2*k+1])); // R9
    AST_DEAD_GAP_P: assert property (@(posedge clk) disable iff (rst)
      $rose(g[2*k]) |-> (off_n >= CW'(DEAD))); // R9
    AST_DEAD_GAP_N: assert property (@(posedge clk) disable iff (rst)
      $rose(g[2*k+1]) |-> (off_p >= CW'(DEAD))); // R9
  end

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (g == 6'b0)); // R2
  AST_POL_AT_VALLEY: assert property (@(posedge clk) disable iff (rst)
    !$stable(neg_q) |-> ($past(wrap) || !$past(en))); // R4
  AST_CLAMP_POS: assert property (@(posedge clk) disable iff (rst)
    (!neg_q && !$past(neg_q)) |-> !gate_c_c); // R5
  AST_CLAMP_NEG: assert property (@(posedge clk) disable iff (rst)
    (neg_q && $past(neg_q)) |-> !gate_c); // R7
  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |->
      ((car_lead == $past(car_lead) + 1'b1) || ($past(car_lead) == car_lead + 1'b1))); // R3

endmodule

bind anpc_gate_gen anpc_gate_gen_chk #(.DEAD(DEAD), .CAR_W(CAR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .wrap     (wrap),
  .neg_q    (neg_q),
  .car_lead (car_lead),
  .gate_a   (gate_a),
  .gate_a_c (gate_a_c),
  .gate_b   (gate_b),
  .gate_b_c (gate_b_c),
  .gate_c   (gate_c),
  .gate_c_c (gate_c_c)
);

// File: tb/test_anpc_gate_gen.sv
module test_anpc_gate_gen;
  localparam int H   = 50;
  localparam int PER = 2 * H;
  localparam int D   = 3;
  localparam int RW  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [RW-1:0] ref_in = '0;
  logic gate_a, gate_a_c, gate_b, gate_b_c, gate_c, gate_c_c;
  logic [5:0] gv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  anpc_gate_gen #(.HALF(H), .REF_W(RW), .DEAD(D)) i_anpc_gate_gen (
    .clk(clk), .rst(rst), .en(en), .ref_in(ref_in),
    .gate_a(gate_a), .gate_a_c(gate_a_c), .gate_b(gate_b),
    .gate_b_c(gate_b_c), .gate_c(gate_c), .gate_c_c(gate_c_c)
  );

  // bit order: 0 a, 1 a_c, 2 b, 3 b_c, 4 c, 5 c_c
  assign gv = {gate_c_c, gate_c, gate_b_c, gate_b, gate_a_c, gate_a};

  // ---------------- requirement model ----------------
  int mp = 0, mmag = 0;
  bit mneg = 0;
  bit [5:0] ex = '0;
  int mgap [3] = '{0, 0, 0};

  function automatic int mag_of(int v);
    int m;
    m = (v < 0) ? -v : v;
    return (m > H) ? H : m;
  endfunction

  function automatic bit [5:0] want(bit e, int p, int m, bit ng);
    int a, b;
    bit l, g;
    if (!e) return 6'b0;
    a = (p <= H) ? p : PER - p;   // R3 lead triangle
    b = H - a;                    // R3 lag carrier
    l = (2 * a + m >= H);         // R5
    g = (m >= H) || (2 * b + m > H); // R6
    if (!ng) return {1'b0, l, !g, g, !l, l};
    else     return {l, 1'b0, l, !l, g, !g}; // R7
  endfunction

  always @(posedge clk) begin : model
    bit [5:0] d, nx;
    int ng [3];
    if (rst) begin
      mp = 0; mmag = 0; mneg = 0; ex = '0;
      for (int k = 0; k < 3; k++) mgap[k] = 0;
    end else begin
      d = want(en, mp, mmag, mneg);
      for (int k = 0; k < 3; k++) begin
        nx[2*k]   = d[2*k]   && (ex[2*k]   || (!ex[2*k+1] && mgap[k] >= D - 1));
        nx[2*k+1] = d[2*k+1] && (ex[2*k+1] || (!ex[2*k]   && mgap[k] >= D - 1));
        ng[k] = (ex[2*k] || ex[2*k+1]) ? 0 : ((mgap[k] < D) ? mgap[k] + 1 : D);
      end
      if (!en || mp == PER - 1) begin
        mmag = mag_of(int'(ref_in));
        mneg = (ref_in < 0);
      end
      mp = (!en || mp == PER - 1) ? 0 : mp + 1;
      ex = nx;
      for (int k = 0; k < 3; k++) mgap[k] = ng[k];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_span(int n, string req);
    int bad = 0;
    int fa = 0, fe = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gv !== ex) begin
        if (bad == 0) begin fa = int'(gv); fe = int'(ex); end
        bad++;
      end
    end
    check(bad == 0, req, "gate vector vs model (first mismatch)", fa, fe);
  endtask

  task automatic count_rises(int n, int idx, output int r);
    bit prev;
    r = 0;
    prev = gv[idx];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gv[idx] && !prev) r++;
      prev = gv[idx];
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(gv == 6'b0, "R1", "gates during reset", int'(gv), 0);
    rst = 1'b0;
  endtask

  task automatic t_positive();
    int r;
    int cc;
    ref_in = 12'sd20;
    en = 1'b1;
    compare_span(3 * PER, "R3");
    compare_span(PER, "R5");
    compare_span(PER, "R6");
    count_rises(2 * PER, 0, r);
    check(r == 2, "R8", "gate_a rises in two periods", r, 2);
    count_rises(2 * PER, 2, r);
    check(r == 2, "R8", "gate_b rises in two periods", r, 2);
    cc = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (gate_c_c) cc++;
    end
    check(cc == 0, "R5", "gate_c_c on-cycles in positive half", cc, 0);
  endtask

  task automatic t_dead();
    bit prev;
    int gap;
    prev = gate_a;
    forever begin
      @(negedge clk);
      if (prev && !gate_a) break;
      prev = gate_a;
    end
    gap = 0;
    while (!gate_a && !gate_a_c) begin gap++; @(negedge clk); end
    check(gap == D, "R9", "gate_a off to gate_a_c on", gap, D);
    prev = gate_a_c;
    forever begin
      @(negedge clk);
      if (prev && !gate_a_c) break;
      prev = gate_a_c;
    end
    gap = 0;
    while (!gate_a && !gate_a_c) begin gap++; @(negedge clk); end
    check(gap == D, "R9", "gate_a_c off to gate_a on", gap, D);
  endtask

  task automatic t_negative();
    int r;
    int cc;
    ref_in = -12'sd20;
    compare_span(3 * PER, "R7");
    cc = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (gate_c) cc++;
    end
    check(cc == 0, "R7", "gate_c on-cycles in negative half", cc, 0);
    count_rises(2 * PER, 5, r);
    check(r == 2, "R7", "gate_c_c rises in two periods", r, 2);
  endtask

  task automatic t_full();
    int bad;
    ref_in = 12'sd2047;
    compare_span(2 * PER, "R4");
    bad = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (gv != 6'b010101) bad++;
    end
    check(bad == 0, "R4", "full positive: a,b,c held on (cycles off)", bad, 0);
    ref_in = -12'sd2048;
    compare_span(2 * PER, "R4");
    bad = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (gv != 6'b101010) bad++;
    end
    check(bad == 0, "R4", "full negative: a_c,b_c,c_c held on (cycles off)", bad, 0);
  endtask

  task automatic t_zero();
    int both;
    ref_in = 12'sd0;
    compare_span(2 * PER, "R8");
    both = 0;
    for (int i = 0; i < 2 * PER; i++) begin
      @(negedge clk);
      if (gate_a && gate_b) both++;
    end
    check(both == 0, "R8", "zero reference: gate_a and gate_b together", both, 0);
  endtask

  task automatic t_boundary();
    int cc;
    int r;
    ref_in = 12'sd20;
    compare_span(2 * PER, "R4");
    while (mp != 30) @(negedge clk);
    ref_in = -12'sd20;
    cc = 0;
    do begin
      @(negedge clk);
      if (gate_c_c) cc++;
    end while (mp != 0);
    check(cc == 0, "R4", "gate_c_c before valley after mid-period sign change", cc, 0);
    count_rises(PER, 5, r);
    check(r == 1, "R4", "gate_c_c rises in the period after the valley", r, 1);
  endtask

  task automatic t_disable();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(gv == 6'b0, "R2", "gates one clock after disable", int'(gv), 0);
    repeat (PER / 2 + 7) @(negedge clk);
    check(gv == 6'b0, "R2", "gates while disabled", int'(gv), 0);
    ref_in = 12'sd20;
    en = 1'b1;
    compare_span(2 * PER, "R2");
  endtask

  initial begin
    t_reset();
    t_positive();
    t_dead();
    t_negative();
    t_full();
    t_zero();
    t_boundary();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule